// File: doc/BRIEF.md
# Unlock-Sequence Command Sequencer

This block is the command front end of a byte-wide nonvolatile memory controller. It watches a bus-write interface that has already been sampled into the clock domain: a one-cycle write strobe with a 17-bit address and an 8-bit data byte. It recognises a guarded four-write command protocol. Two fixed unlock writes come first, then a write that carries the command byte, then an operand write. Only then does it hand the command code, the operand address and the operand data to a separate execution unit. It issues them as a single-cycle pulse with registered operands.

Malformed traffic sets a sticky error flag. This covers wrong unlock writes, an unsupported or conflicting command byte, too long a pause between writes, writes that arrive while the execution unit is busy, and a supply-lockout indication during execution. Only a completed Reset command clears the flag. A free-running microsecond tick measures the pause between writes. The pause limit, the bus widths and the strictness of command decoding are parameters.

Top module: `unlock_cmd_seq`

## Requirements
- R1: After reset the error flag is 0, the issue pulse is 0 and the issued command, address and data outputs are 0.
- R2: A sequence of writes (5555h, AAh), (2AAAh, 55h), (5555h, C) and (A, D), with C a valid code, raises `issue` for exactly one cycle. This happens in the cycle after the fourth write, with `issue_cmd`=C, `issue_addr`=A and `issue_data`=D. The valid codes are 00h Reset, 01h Status, 02h ID read, 04h Verify-0, 08h Verify-1, 10h Converge, 40h Program and 80h Erase.
- R3: A first, second or third write whose address (or, for the first two writes, data) differs from the unlock values sets the error flag. The partial sequence is dropped, no command is issued, and the next write is taken as a first write.
- R4: A command byte with more than one bit set, or the unused single-bit value 20h, sets the error flag and issues nothing.
- R5: Counting the tick pulses seen strictly between two writes of one sequence, a count above GAP_US (default 150) at the second, third or fourth write sets the error flag and drops the sequence. A count of exactly GAP_US is accepted.
- R6: The error flag is sticky. A command other than Reset leaves it set. It clears in the cycle in which a Reset (00h) command is issued, unless a new error is raised in the same cycle.
- R7: A write while `exec_busy` is high, or in the cycle in which `issue` is high, sets the error flag. It is not counted toward any sequence.
- R8: `lockout` high while the execution unit is busy sets the error flag. `lockout` high while idle has no effect.
- R9: The issued command, address and data outputs hold their values from one issue to the next.
- R10: Each command needs its own full four-write sequence. A lone operand-style write after an issue sets the error flag and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_en | input | 1 | Sampled bus write strobe, one cycle per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| lockout | input | 1 | Low-supply lockout indication |
| exec_busy | input | 1 | Execution unit is running a command |
| issue | output | 1 | One-cycle command issue pulse |
| issue_cmd | output | 8 | Issued command code |
| issue_addr | output | 17 | Issued operand address |
| issue_data | output | 8 | Issued operand data |
| err_flag | output | 1 | Sticky sequence error flag |

## Verification
Clean sequences for every valid command show that the code and both operands reach the outputs intact and that the pulse lasts one cycle. Sequences corrupted in the first, second or third write show that each unlock stage is checked and that recovery starts over cleanly. Gap stimulus at exactly the limit and one tick beyond it separates the inclusive boundary from an off-by-one. Writes and lockout pulses timed during the issue cycle and during busy windows tell rejected traffic apart from counted traffic, and Status-versus-Reset sequences tell the sticky behaviour apart from the clearing path.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

   typedef enum logic [1:0] {
      ST_UNLOCK_A = 2'd0,
      ST_UNLOCK_B = 2'd1,
      ST_OPCODE   = 2'd2,
      ST_OPERAND  = 2'd3
   } seq_stage_e;

   localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
   localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
   localparam logic [7:0]  UNLOCK_DATA_A = 8'hAA;
   localparam logic [7:0]  UNLOCK_DATA_B = 8'h55;
   localparam logic [7:0]  OPC_RESET     = 8'h00;
   // Single-bit positions that carry a defined command (20h is unused).
   localparam logic [7:0]  OPC_BIT_MASK  = 8'hDF;

endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
   parameter int unsigned LIMIT = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 2);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (tick && (cnt <= CW'(LIMIT)))
         cnt <= cnt + 1'b1;
   end

   assign expired = (cnt > CW'(LIMIT));
endmodule

// File: rtl/seq_code_check.sv
module seq_code_check #(
   parameter int unsigned DATA_W        = 8,
   parameter bit          REJECT_UNUSED = 1'b1
) (
   input  logic [DATA_W-1:0] code,
   output logic              legal
);
   import cmd_seq_pkg::*;

   logic at_most_one;
   assign at_most_one = ($countones(code) <= 1);

   generate
      if (REJECT_UNUSED) begin : g_strict
         assign legal = at_most_one && ((code & ~DATA_W'(OPC_BIT_MASK)) == '0);
      end else begin : g_loose
         assign legal = at_most_one;
      end
   endgenerate
endmodule

// File: rtl/seq_err_flag.sv
module seq_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/unlock_cmd_seq.sv
module unlock_cmd_seq #(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned GAP_US        = 150,
   parameter bit          REJECT_UNUSED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lockout,
   input  logic              exec_busy,
   output logic              issue,
   output logic [DATA_W-1:0] issue_cmd,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [DATA_W-1:0] issue_data,
   output logic              err_flag
);
   import cmd_seq_pkg::*;

   localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
   localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);
   localparam logic [DATA_W-1:0] DATA_A = DATA_W'(UNLOCK_DATA_A);
   localparam logic [DATA_W-1:0] DATA_B = DATA_W'(UNLOCK_DATA_B);
   localparam logic [DATA_W-1:0] RESET_OPC = DATA_W'(OPC_RESET);

   generate
      if (ADDR_W < 16) begin : g_bad_addr_w
         $error("unlock_cmd_seq: ADDR_W must hold the unlock addresses");
      end
      if (DATA_W != 8) begin : g_bad_data_w
         $error("unlock_cmd_seq: DATA_W must be 8");
      end
      if (GAP_US < 1) begin : g_bad_gap
         $error("unlock_cmd_seq: GAP_US must be at least 1");
      end
   endgenerate

   seq_stage_e        stage_q, stage_d;
   logic [DATA_W-1:0] opc_q;
   logic              capture_opc;
   logic              go_issue;
   logic              set_err;
   logic              busy_eff;
   logic              gap_over;
   logic              opc_legal;

   assign busy_eff = exec_busy | issue;

   seq_gap_timer #(.LIMIT(GAP_US)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (us_tick),
      .restart (wr_en),
      .expired (gap_over)
   );

   seq_code_check #(.DATA_W(DATA_W), .REJECT_UNUSED(REJECT_UNUSED)) u_code (
      .code  (wr_data),
      .legal (opc_legal)
   );

   always_comb begin
      stage_d     = stage_q;
      capture_opc = 1'b0;
      go_issue    = 1'b0;
      set_err     = 1'b0;
      if (wr_en) begin
         if (busy_eff) begin
            set_err = 1'b1;
            stage_d = ST_UNLOCK_A;
         end else begin
            unique case (stage_q)
               ST_UNLOCK_A: begin
                  if (wr_addr == ADDR_A && wr_data == DATA_A)
                     stage_d = ST_UNLOCK_B;
                  else
                     set_err = 1'b1;
               end
               ST_UNLOCK_B: begin
                  if (!gap_over && wr_addr == ADDR_B && wr_data == DATA_B)
                     stage_d = ST_OPCODE;
                  else begin
                     set_err = 1'b1;
                     stage_d = ST_UNLOCK_A;
                  end
               end
               ST_OPCODE: begin
                  if (!gap_over && wr_addr == ADDR_A && opc_legal) begin
                     stage_d     = ST_OPERAND;
                     capture_opc = 1'b1;
                  end else begin
                     set_err = 1'b1;
                     stage_d = ST_UNLOCK_A;
                  end
               end
               ST_OPERAND: begin
                  if (!gap_over)
                     go_issue = 1'b1;
                  else
                     set_err = 1'b1;
                  stage_d = ST_UNLOCK_A;
               end
               default: stage_d = ST_UNLOCK_A;
            endcase
         end
      end
      if (lockout && busy_eff)
         set_err = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q    <= ST_UNLOCK_A;
         opc_q      <= '0;
         issue      <= 1'b0;
         issue_cmd  <= '0;
         issue_addr <= '0;
         issue_data <= '0;
      end else begin
         stage_q <= stage_d;
         issue   <= go_issue;
         if (capture_opc)
            opc_q <= wr_data;
         if (go_issue) begin
            issue_cmd  <= opc_q;
            issue_addr <= wr_addr;
            issue_data <= wr_data;
         end
      end
   end

   seq_err_flag u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_err),
      .clr_i  (go_issue && (opc_q == RESET_OPC)),
      .flag_o (err_flag)
   );
endmodule

// File: rtl/unlock_cmd_seq_chk.sv
module unlock_cmd_seq_chk #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              lockout,
   input logic              exec_busy,
   input logic              issue,
   input logic [DATA_W-1:0] issue_cmd,
   input logic [ADDR_W-1:0] issue_addr,
   input logic [DATA_W-1:0] issue_data,
   input logic              err_flag
);
   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue);

   // R4
   legal_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (($countones(issue_cmd) <= 1) && (issue_cmd != 8'h20)));

   // R6
   clear_by_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> (issue && issue_cmd == '0));

   // R7
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && exec_busy) |=> (err_flag && !issue));

   // R8
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lockout && exec_busy) |=> err_flag);

   // R9
   operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> ($stable(issue_cmd) && $stable(issue_addr) && $stable(issue_data)));
endmodule

bind unlock_cmd_seq unlock_cmd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .lockout    (lockout),
   .exec_busy  (exec_busy),
   .issue      (issue),
   .issue_cmd  (issue_cmd),
   .issue_addr (issue_addr),
   .issue_data (issue_data),
   .err_flag   (err_flag)
);

// File: tb/sim_unlock_cmd_seq.sv
`timescale 1ns/1ps
module sim_unlock_cmd_seq;
   localparam int GAP = 150;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        us_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        lockout = 1'b0;
   logic        exec_busy = 1'b0;
   logic        issue;
   logic [7:0]  issue_cmd;
   logic [16:0] issue_addr;
   logic [7:0]  issue_data;
   logic        err_flag;

   always #2 clk = ~clk;

   unlock_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .lockout(lockout),
      .exec_busy(exec_busy), .issue(issue), .issue_cmd(issue_cmd),
      .issue_addr(issue_addr), .issue_data(issue_data), .err_flag(err_flag)
   );

   int n_chk = 0;
   int n_bad = 0;
   string tag = "R1";

   // reference model state
   int          m_st = 0;
   logic        m_err = 1'b0;
   logic        m_issue = 1'b0;
   logic [7:0]  m_opc = '0;
   int          m_gap = 0;
   logic [7:0]  e_cmd = '0;
   logic [16:0] e_addr = '0;
   logic [7:0]  e_data = '0;

   function automatic logic opc_ok(input logic [7:0] c);
      return ($countones(c) <= 1) && (c != 8'h20);
   endfunction

   task automatic chk(input string t, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(tag, "issue", issue, m_issue);
      chk(tag, "err_flag", err_flag, m_err);
      chk(tag, "issue_cmd", issue_cmd, e_cmd);
      chk(tag, "issue_addr", issue_addr, e_addr);
      chk(tag, "issue_data", issue_data, e_data);
   endtask

   task automatic step(input logic we, input logic [16:0] a, input logic [7:0] d,
                       input logic tk, input logic lk);
      logic busy, set, nis;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; us_tick = tk; lockout = lk;
      busy = exec_busy | m_issue;
      set = 1'b0; nis = 1'b0;
      if (we) begin
         if (busy) begin
            set = 1'b1; m_st = 0;
         end else begin
            case (m_st)
               0: if (a == 17'h5555 && d == 8'hAA) m_st = 1; else set = 1'b1;
               1: if (m_gap <= GAP && a == 17'h2AAA && d == 8'h55) m_st = 2;
                  else begin set = 1'b1; m_st = 0; end
               2: if (m_gap <= GAP && a == 17'h5555 && opc_ok(d)) begin m_st = 3; m_opc = d; end
                  else begin set = 1'b1; m_st = 0; end
               default: begin
                  if (m_gap <= GAP) nis = 1'b1; else set = 1'b1;
                  m_st = 0;
               end
            endcase
         end
         m_gap = 0;
      end else if (tk) m_gap++;
      if (lk && busy) set = 1'b1;
      if (nis) begin
         e_cmd = m_opc; e_addr = a; e_data = d;
         if (m_opc == 8'h00) m_err = 1'b0;
      end
      if (set) m_err = 1'b1;
      m_issue = nis;
      @(posedge clk);
      #1;
      wr_en = 1'b0; us_tick = 1'b0; lockout = 1'b0;
      compare_all();
   endtask

   task automatic wr(input logic [16:0] a, input logic [7:0] d);
      step(1'b1, a, d, 1'b0, 1'b0);
   endtask

   task automatic idle(input int n, input logic tk);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, tk, 1'b0);
   endtask

   task automatic cmd_seq(input logic [7:0] c, input logic [16:0] a, input logic [7:0] d);
      wr(17'h5555, 8'hAA); wr(17'h2AAA, 8'h55); wr(17'h5555, c); wr(a, d);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] codes [8];
      codes = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h40, 8'h80};
      void'($urandom(32'h5EED1));
      repeat (3) @(posedge clk);
      #1;
      tag = "R1"; compare_all();
      rst_n = 1'b1;
      idle(2, 1'b0);

      // R2: program command, then pulse drops
      tag = "R2"; cmd_seq(8'h40, 17'h1_2345, 8'h5A);
      chk("R2", "issue after write4", issue, 1);
      idle(1, 1'b0);
      chk("R2", "pulse width", issue, 0);

      // R9: operands held across a busy window
      tag = "R9"; exec_busy = 1'b1; idle(5, 1'b0);
      chk("R9", "held addr", issue_addr, 17'h1_2345);

      // R7: write while busy is counted as error, not as a first write
      tag = "R7"; wr(17'h5555, 8'hAA); exec_busy = 1'b0;
      chk("R7", "err after busy write", err_flag, 1);
      cmd_seq(8'h08, 17'h0_0777, 8'h33);
      chk("R7", "fresh sequence issues", issue, 1);
      // R7: write in the issue cycle itself
      wr(17'h5555, 8'hAA);
      idle(1, 1'b0);

      // R6: status keeps the flag, reset clears it
      tag = "R6"; cmd_seq(8'h01, 17'h0, 8'h0);
      chk("R6", "status keeps err", err_flag, 1);
      idle(1, 1'b0);
      cmd_seq(8'h00, 17'h0, 8'h0);
      chk("R6", "reset clears err", err_flag, 0);
      idle(1, 1'b0);

      // R3: bad first, second, third writes
      tag = "R3"; wr(17'h5555, 8'hAB);
      chk("R3", "bad write1", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);
      wr(17'h5555, 8'hAA); wr(17'h2AAB, 8'h55);
      chk("R3", "bad write2", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);
      wr(17'h5555, 8'hAA); wr(17'h2AAA, 8'h55); wr(17'h5554, 8'h40);
      wr(17'h0_1111, 8'h22);
      chk("R3", "no issue after bad write3", issue, 0);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);

      // R4: conflicting and unused command bytes
      tag = "R4"; wr(17'h5555, 8'hAA); wr(17'h2AAA, 8'h55); wr(17'h5555, 8'h03);
      chk("R4", "multi-bit code", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);
      wr(17'h5555, 8'hAA); wr(17'h2AAA, 8'h55); wr(17'h5555, 8'h20);
      chk("R4", "unused code 20h", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);

      // R5: gap exactly at the limit, then one beyond
      tag = "R5";
      wr(17'h5555, 8'hAA); idle(GAP, 1'b1); wr(17'h2AAA, 8'h55);
      idle(GAP, 1'b1); wr(17'h5555, 8'h80); idle(GAP, 1'b1); wr(17'h1_8000, 8'hFF);
      chk("R5", "gap at limit issues", issue, 1);
      chk("R5", "gap at limit no err", err_flag, 0);
      idle(1, 1'b0);
      wr(17'h5555, 8'hAA); idle(GAP + 1, 1'b1); wr(17'h2AAA, 8'h55);
      chk("R5", "gap beyond limit", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);

      // R8: lockout idle vs busy
      tag = "R8"; step(1'b0, '0, '0, 1'b0, 1'b1);
      chk("R8", "lockout idle", err_flag, 0);
      exec_busy = 1'b1; step(1'b0, '0, '0, 1'b0, 1'b1); exec_busy = 1'b0;
      chk("R8", "lockout busy", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);

      // R10: lone operand write after an issue
      tag = "R10"; cmd_seq(8'h10, 17'h0_4444, 8'h00); idle(1, 1'b0);
      wr(17'h0_4445, 8'h00);
      chk("R10", "lone operand write", issue, 0);
      chk("R10", "lone operand err", err_flag, 1);
      cmd_seq(8'h00, 17'h0, 8'h0); idle(1, 1'b0);

      // random mix against the model (R2 R3 R4 R7 R8 R9)
      tag = "R2";
      for (int it = 0; it < 200; it++) begin
         int kind;
         logic [7:0] c;
         kind = $urandom_range(0, 7);
         exec_busy = ($urandom_range(0, 7) == 0);
         c = (kind == 3) ? 8'($urandom) : codes[$urandom_range(0, 7)];
         wr(17'h5555, (kind == 1) ? 8'hA8 : 8'hAA);
         idle($urandom_range(0, 2), 1'b0);
         wr((kind == 2) ? 17'h2AAE : 17'h2AAA, 8'h55);
         wr(17'h5555, c);
         idle($urandom_range(0, 2), 1'b0);
         wr(17'($urandom), 8'($urandom));
         step(1'b0, '0, '0, 1'b0, ($urandom_range(0, 15) == 0));
         exec_busy = 1'b0;
         idle(1, 1'b0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule